// File: doc/BRIEF.md
# SPI Transfer Length Sequencer

This block sits in front of a serial shift engine and paces a complete SPI transfer one word at a time. Software sets the word count through two register fields (a 4-bit upper part and a 16-bit lower part) and selects transmit, receive or both through a two-bit mode field. For each word the sequencer pulses a launch request to the engine and then waits for the engine's per-word done strobes before it issues the next one. The shifting and the data FIFOs sit outside this block.

Receive-only transfers take their own 9-bit count and start from a separate start bit, and the sequencer launches dummy words so that the engine clocks data in. A request-launch mode suits three-wire or dual-line operation: it holds every start until a software request pulse arrives. When a transfer finishes, the sequencer raises transmit-end and/or receive-end events. Each event lands in a raw status bit that software clears by writing a one. An enable mask selects which raw bits drive the interrupt line.

Register writes use `wr_sel`: 0 = length low (data[15:0]), 1 = length high (data[3:0]), 2 = mode (bit0 receive, bit1 transmit, bit2 request-launch), 3 = receive-only count (data[8:0]) plus start (data[9]), 4 = interrupt enable, 5 = interrupt clear. In the enable, clear and both status words, transmit-end is bit 8 and receive-end is bit 9.

Top module: `spi_xfer_seq`

## Requirements
- R1: The transfer count in transmit and full-duplex modes is {length high[3:0], length low[15:0]}, 20 bits wide. Exactly that many words are launched.
- R2: At most one word is in flight. After a launch pulse, no further launch comes until the done strobes needed for that word have arrived.
- R3: In transmit-only mode (mode = 2) a mode write starts the transfer. Each word completes on `word_tx_done`. Raw bit 8 sets when the count is done, and bit 9 stays clear.
- R4: In full-duplex mode (mode = 3) a word completes only after both `word_tx_done` and `word_rx_done`. Both raw bits 8 and 9 set at the end.
- R5: In receive-only mode (mode = 1), writing the mode does not start a transfer. Writing register 3 with data[9]=1 starts it. The count is the 9-bit data[8:0], each word completes on `word_rx_done`, and only raw bit 9 sets. A start bit written in any other mode has no effect.
- R6: With request-launch set (mode bit 2), no start happens until a `sw_req` pulse arrives. With request-launch clear, `sw_req` has no effect.
- R7: Writing mode 0 aborts a running transfer. `busy` drops within two cycles and no end event is raised.
- R8: `sts_masked` equals `sts_raw` ANDed with the enable register, and `irq` is the OR of `sts_masked`.
- R9: Writing a one to a clear bit resets the matching raw bit. If an end event arrives in the same cycle as the clear, the raw bit stays set.
- R10: A zero count finishes without any launch and still raises the end event(s) of the selected mode.
- R11: After reset the block is idle, with no launch request, no interrupt and all status bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 16 | Register write data |
| sw_req | input | 1 | Software launch request pulse |
| word_tx_done | input | 1 | Engine finished sending one word |
| word_rx_done | input | 1 | Engine finished receiving one word |
| word_launch | output | 1 | Request to the engine to start one word |
| busy | output | 1 | A transfer is in progress |
| irq | output | 1 | Interrupt line |
| sts_raw | output | 16 | Raw event status (bits 8, 9) |
| sts_masked | output | 16 | Raw status ANDed with enable |

## Verification
The assertions assume that the engine raises each done strobe for a single cycle, and only for a word that was actually launched. They also assume that software does not restart a mode while a transfer is running. The directed bench follows these rules. Its engine model answers each observed launch with exactly one strobe per required direction, two cycles later. Every mode, count or abort write comes either from idle or as an abort with mode 0.

// File: rtl/spi_xfer_seq_pkg.sv
package spi_xfer_seq_pkg;
  localparam int REG_W       = 16;
  localparam int SEL_W       = 3;
  localparam int EVT_TX_BIT  = 8;
  localparam int EVT_RX_BIT  = 9;
  localparam int MODE_RX_BIT = 0;
  localparam int MODE_TX_BIT = 1;
  localparam int MODE_RQ_BIT = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_LEN_LO  = 3'd0,
    SEL_LEN_HI  = 3'd1,
    SEL_MODE    = 3'd2,
    SEL_RXO     = 3'd3,
    SEL_INT_EN  = 3'd4,
    SEL_INT_CLR = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } seq_st_e;

  // A word is complete once every direction it needs has reported done.
  function automatic logic word_complete(input logic need_tx, input logic need_rx,
                                         input logic got_tx, input logic got_rx);
    return (got_tx || !need_tx) && (got_rx || !need_rx);
  endfunction

  // Receive-only selects the short count; every other mode uses the joined length.
  function automatic logic rx_only(input logic tx_on, input logic rx_on);
    return rx_on && !tx_on;
  endfunction
endpackage

// File: rtl/spi_xfer_seq_cfg.sv
module spi_xfer_seq_cfg
  import spi_xfer_seq_pkg::*;
#(
  parameter int LEN_HI_W = 4,
  parameter int LEN_LO_W = 16,
  parameter int RXO_W    = 9,
  localparam int LEN_W   = LEN_HI_W + LEN_LO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               sw_req,
  output logic               tx_en,
  output logic               rx_en,
  output logic               mode_off,
  output logic [LEN_W-1:0]   tgt,
  output logic               start_q
);
  logic [LEN_HI_W-1:0] len_hi_q;
  logic [LEN_LO_W-1:0] len_lo_q;
  logic [RXO_W-1:0]    rxo_q;
  logic                req_md;
  logic                start_d;
  reg_sel_e            sel;

  assign sel      = reg_sel_e'(wr_sel);
  assign mode_off = !(tx_en || rx_en);
  assign tgt      = rx_only(tx_en, rx_en) ? {{(LEN_W-RXO_W){1'b0}}, rxo_q}
                                          : {len_hi_q, len_lo_q};

  // Start decision: evaluated on the write, acted on one cycle later so the
  // controller always sees the settled mode and count.
  always_comb begin
    start_d = 1'b0;
    if (wr_en && sel == SEL_MODE && !wr_data[MODE_RQ_BIT] && wr_data[MODE_TX_BIT])
      start_d = 1'b1;
    if (wr_en && sel == SEL_RXO && wr_data[RXO_W] && !req_md && rx_only(tx_en, rx_en))
      start_d = 1'b1;
    if (sw_req && req_md && !mode_off)
      start_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_hi_q <= '0;
      len_lo_q <= '0;
      rxo_q    <= '0;
      tx_en    <= 1'b0;
      rx_en    <= 1'b0;
      req_md   <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      if (wr_en) begin
        case (sel)
          SEL_LEN_LO: len_lo_q <= wr_data[LEN_LO_W-1:0];
          SEL_LEN_HI: len_hi_q <= wr_data[LEN_HI_W-1:0];
          SEL_MODE: begin
            rx_en  <= wr_data[MODE_RX_BIT];
            tx_en  <= wr_data[MODE_TX_BIT];
            req_md <= wr_data[MODE_RQ_BIT];
          end
          SEL_RXO: rxo_q <= wr_data[RXO_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_xfer_seq_ctl.sv
module spi_xfer_seq_ctl
  import spi_xfer_seq_pkg::*;
#(
  parameter int LEN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_q,
  input  logic             mode_off,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic [LEN_W-1:0] tgt,
  input  logic             word_tx_done,
  input  logic             word_rx_done,
  output logic             word_launch,
  output logic             busy,
  output logic             evt_tx_end,
  output logic             evt_rx_end
);
  seq_st_e          st;
  logic [LEN_W-1:0] tgt_q;
  logic [LEN_W-1:0] sent_q;
  logic             need_tx, need_rx, seen_tx, seen_rx;
  logic             all_sent, finish, word_ok;

  assign all_sent    = (sent_q == tgt_q);
  assign word_launch = (st == ST_RUN) && !all_sent;
  assign finish      = (st == ST_RUN) && all_sent;
  assign evt_tx_end  = finish && need_tx;
  assign evt_rx_end  = finish && need_rx;
  assign busy        = (st != ST_IDLE);
  assign word_ok     = word_complete(need_tx, need_rx,
                                     seen_tx || word_tx_done, seen_rx || word_rx_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      tgt_q   <= '0;
      sent_q  <= '0;
      need_tx <= 1'b0;
      need_rx <= 1'b0;
      seen_tx <= 1'b0;
      seen_rx <= 1'b0;
    end else if (mode_off) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (start_q) begin
          tgt_q   <= tgt;
          sent_q  <= '0;
          need_tx <= tx_en;
          need_rx <= rx_en;
          st      <= ST_RUN;
        end
        ST_RUN: if (word_launch) begin
          sent_q  <= sent_q + LEN_W'(1);
          seen_tx <= 1'b0;
          seen_rx <= 1'b0;
          st      <= ST_WAIT;
        end else begin
          st <= ST_IDLE;
        end
        ST_WAIT: begin
          seen_tx <= seen_tx || word_tx_done;
          seen_rx <= seen_rx || word_rx_done;
          if (word_ok) st <= ST_RUN;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_single_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_launch |=> !word_launch);
  assert_end_goes_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_tx_end || evt_rx_end) |=> !busy);
  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_off |=> !busy);
endmodule

// File: rtl/spi_xfer_seq_irq.sv
module spi_xfer_seq_irq
  import spi_xfer_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             clr_wr,
  input  logic [1:0]       wr_bits,
  input  logic             evt_tx_end,
  input  logic             evt_rx_end,
  output logic [REG_W-1:0] sts_raw,
  output logic [REG_W-1:0] sts_masked,
  output logic             irq
);
  logic [1:0] en_q;   // [0] transmit end, [1] receive end
  logic [1:0] raw_q;
  logic [1:0] evt;

  assign evt = {evt_rx_end, evt_tx_end};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      raw_q <= '0;
    end else begin
      if (en_wr) en_q <= wr_bits;
      // A new event beats a clear arriving in the same cycle.
      raw_q <= evt | (raw_q & ~(clr_wr ? wr_bits : 2'b00));
    end
  end

  always_comb begin
    sts_raw                = '0;
    sts_raw[EVT_TX_BIT]    = raw_q[0];
    sts_raw[EVT_RX_BIT]    = raw_q[1];
    sts_masked             = '0;
    sts_masked[EVT_TX_BIT] = raw_q[0] && en_q[0];
    sts_masked[EVT_RX_BIT] = raw_q[1] && en_q[1];
    irq                    = |sts_masked;
  end

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tx_end |=> sts_raw[EVT_TX_BIT]);
  assert_clear_takes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && wr_bits[0] && !evt_tx_end) |=> !sts_raw[EVT_TX_BIT]);
endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
  import spi_xfer_seq_pkg::*;
#(
  parameter int LEN_HI_W = 4,
  parameter int LEN_LO_W = 16,
  parameter int RXO_W    = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [15:0] wr_data,
  input  logic        sw_req,
  input  logic        word_tx_done,
  input  logic        word_rx_done,
  output logic        word_launch,
  output logic        busy,
  output logic        irq,
  output logic [15:0] sts_raw,
  output logic [15:0] sts_masked
);
  localparam int LEN_W = LEN_HI_W + LEN_LO_W;

  logic             tx_en, rx_en, mode_off, start_q;
  logic [LEN_W-1:0] tgt;
  logic             evt_tx_end, evt_rx_end;
  logic             en_wr, clr_wr;

  assign en_wr  = wr_en && (reg_sel_e'(wr_sel) == SEL_INT_EN);
  assign clr_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_INT_CLR);

  spi_xfer_seq_cfg #(.LEN_HI_W(LEN_HI_W), .LEN_LO_W(LEN_LO_W), .RXO_W(RXO_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sw_req(sw_req), .tx_en(tx_en), .rx_en(rx_en), .mode_off(mode_off),
    .tgt(tgt), .start_q(start_q)
  );

  spi_xfer_seq_ctl #(.LEN_W(LEN_W)) ctl_i (
    .clk(clk), .rst_n(rst_n), .start_q(start_q), .mode_off(mode_off),
    .tx_en(tx_en), .rx_en(rx_en), .tgt(tgt),
    .word_tx_done(word_tx_done), .word_rx_done(word_rx_done),
    .word_launch(word_launch), .busy(busy),
    .evt_tx_end(evt_tx_end), .evt_rx_end(evt_rx_end)
  );

  spi_xfer_seq_irq irq_i (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .clr_wr(clr_wr),
    .wr_bits({wr_data[EVT_RX_BIT], wr_data[EVT_TX_BIT]}),
    .evt_tx_end(evt_tx_end), .evt_rx_end(evt_rx_end),
    .sts_raw(sts_raw), .sts_masked(sts_masked), .irq(irq)
  );
endmodule

// File: tb/spi_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module spi_xfer_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        sw_req = 1'b0;
  logic        tx_d = 1'b0;
  logic        rx_d = 1'b0;
  logic        word_launch, busy, irq;
  logic [15:0] sts_raw, sts_masked;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spi_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sw_req(sw_req), .word_tx_done(tx_d), .word_rx_done(rx_d),
    .word_launch(word_launch), .busy(busy), .irq(irq),
    .sts_raw(sts_raw), .sts_masked(sts_masked)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] sel, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    sw_req = 1'b1;
    @(negedge clk);
    sw_req = 1'b0;
  endtask

  // Engine model: answer each launch two cycles later; returns launches seen.
  task automatic serve(input bit do_tx, input bit do_rx, input int max_n, output int n);
    int g;
    n = 0; g = 0;
    while (busy && g < 5000 && n < max_n) begin
      if (word_launch) begin
        n++;
        @(negedge clk);
        tx_d = do_tx; rx_d = do_rx;
        @(negedge clk);
        tx_d = 1'b0; rx_d = 1'b0;
      end else begin
        @(negedge clk);
      end
      g++;
    end
  endtask

  task automatic clear_all();
    reg_wr(3'd5, 16'h0300);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11", "busy", busy, 0);
    check("R11", "launch", word_launch, 0);
    check("R11", "irq", irq, 0);
    check("R11", "raw", sts_raw, 0);
  endtask

  task automatic t_tx_only();
    int n;
    reg_wr(3'd1, 16'h0000);
    reg_wr(3'd0, 16'd5);
    reg_wr(3'd2, 16'h0002);
    @(negedge clk);
    serve(1'b1, 1'b0, 100, n);
    check("R1", "tx word count", n, 5);
    check("R3", "raw after tx-only", sts_raw, 16'h0100);
    check("R3", "busy after tx-only", busy, 0);
    clear_all();
  endtask

  task automatic t_high_field_abort();
    int n;
    reg_wr(3'd1, 16'h0001);
    reg_wr(3'd0, 16'd2);
    reg_wr(3'd2, 16'h0002);
    @(negedge clk);
    serve(1'b1, 1'b0, 40, n);
    check("R1", "high field extends count", n, 40);
    check("R1", "still busy past low field", busy, 1);
    reg_wr(3'd2, 16'h0000);
    @(negedge clk);
    check("R7", "busy after abort", busy, 0);
    check("R7", "no event on abort", sts_raw, 0);
    reg_wr(3'd1, 16'h0000);
  endtask

  task automatic t_duplex();
    int n;
    reg_wr(3'd0, 16'd3);
    reg_wr(3'd2, 16'h0003);
    @(negedge clk);
    check("R4", "first launch", word_launch, 1);
    @(negedge clk);
    tx_d = 1'b1;
    @(negedge clk);
    tx_d = 1'b0;
    repeat (3) @(negedge clk);
    check("R2", "no launch with rx pending", word_launch, 0);
    check("R4", "busy with rx pending", busy, 1);
    rx_d = 1'b1;
    @(negedge clk);
    rx_d = 1'b0;
    serve(1'b1, 1'b1, 100, n);
    check("R4", "remaining duplex words", n, 2);
    check("R4", "both ends raw", sts_raw, 16'h0300);
    clear_all();
  endtask

  task automatic t_rx_only();
    int n;
    reg_wr(3'd0, 16'd7);
    reg_wr(3'd2, 16'h0001);
    repeat (3) @(negedge clk);
    check("R5", "mode write alone no start", busy, 0);
    reg_wr(3'd3, 16'h0204);
    @(negedge clk);
    serve(1'b0, 1'b1, 100, n);
    check("R5", "rx-only uses short count", n, 4);
    check("R5", "only rx end raw", sts_raw, 16'h0200);
    clear_all();
  endtask

  task automatic t_start_ignored();
    int n;
    reg_wr(3'd0, 16'd1);
    reg_wr(3'd2, 16'h0002);
    @(negedge clk);
    serve(1'b1, 1'b0, 100, n);
    clear_all();
    reg_wr(3'd3, 16'h0203);
    repeat (3) @(negedge clk);
    check("R5", "start bit ignored in tx mode", busy, 0);
    check("R5", "no event from ignored start", sts_raw, 0);
  endtask

  task automatic t_request();
    int n;
    reg_wr(3'd0, 16'd2);
    reg_wr(3'd2, 16'h0006);
    repeat (3) @(negedge clk);
    check("R6", "request mode waits", busy, 0);
    pulse_req();
    @(negedge clk);
    serve(1'b1, 1'b0, 100, n);
    check("R6", "words after request", n, 2);
    clear_all();
    reg_wr(3'd2, 16'h0001);
    pulse_req();
    repeat (3) @(negedge clk);
    check("R6", "request ignored without mode bit", busy, 0);
  endtask

  task automatic t_zero();
    int n;
    reg_wr(3'd0, 16'd0);
    reg_wr(3'd2, 16'h0002);
    @(negedge clk);
    serve(1'b1, 1'b0, 100, n);
    check("R10", "zero count launches", n, 0);
    check("R10", "zero count end raw", sts_raw, 16'h0100);
  endtask

  task automatic t_mask();
    reg_wr(3'd4, 16'h0100);
    check("R8", "masked with enable", sts_masked, 16'h0100);
    check("R8", "irq with enable", irq, 1);
    reg_wr(3'd4, 16'h0200);
    check("R8", "masked disabled", sts_masked, 0);
    check("R8", "irq disabled", irq, 0);
    check("R8", "raw kept", sts_raw, 16'h0100);
    reg_wr(3'd4, 16'h0000);
  endtask

  task automatic t_clear();
    reg_wr(3'd5, 16'h0100);
    check("R9", "w1c clears", sts_raw, 0);
    reg_wr(3'd0, 16'd1);
    reg_wr(3'd2, 16'h0002);
    @(negedge clk);
    check("R9", "launch before collision", word_launch, 1);
    @(negedge clk);
    tx_d = 1'b1;
    @(negedge clk);
    tx_d = 1'b0;
    wr_en = 1'b1; wr_sel = 3'd5; wr_data = 16'h0100;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9", "event wins over clear", sts_raw, 16'h0100);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_only();
    t_high_field_abort();
    t_duplex();
    t_rx_only();
    t_start_ignored();
    t_request();
    t_zero();
    t_mask();
    t_clear();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule